// File: doc/BRIEF.md
# Write-Only Two-Wire Setup/Configuration Slave

This block is the serial control front end of a small data converter. It sits on a two-wire bus (clock plus open-drain data) as a write-only slave. It recognises its own 7-bit address, acknowledges write transfers addressed to it and files each data byte into one of two registers. The top bit of each byte selects the register, so no register pointer is needed. The decoded fields drive the rest of the converter directly: reference selection, clock source, input polarity mode and the seven configuration bits.

The bus lines are sampled on a fast system clock, at least eight times the bus clock rate. A multi-stage synchroniser comes first, then START, STOP and clock-edge detection. Data is driven only by pulling low. `sda_oe` high means the pad pulls the line to zero. One setup bit works as a command rather than stored state: when it is written as 0, the configuration register returns to its default, and the setup register still takes the new value. A high-speed master code on the bus sets a mode flag, and only a STOP clears that flag.

Top module: `conv_setup_i2c_slave`

## Requirements
- R1: A START followed by an address byte whose upper 7 bits equal `DEV_ADDR` and whose bit 0 (direction) is 0 is acknowledged: `sda_oe` is high during the ninth clock of that byte.
- R2: An address byte with a different address, or with direction bit 1, is not acknowledged. Every later byte up to the next START or STOP is not acknowledged and leaves all register outputs unchanged.
- R3: A data byte with bit 7 = 1 loads the setup register: bits 6:4 go to `ref_sel`, bit 3 to `ext_clk` (1 = external) and bit 2 to `bipolar` (1 = bipolar). Bit 0 has no effect.
- R4: A data byte with bit 7 = 0 loads bits 6:0 into `cfg_q`.
- R5: Every data byte received after an acknowledged address is acknowledged. One or two data bytes in either order are each routed by their own bit 7.
- R6: A setup byte with bit 1 = 0 sets `cfg_q` to `CFG_DEFAULT` in the same commit that loads the setup fields. With bit 1 = 1, `cfg_q` is unchanged.
- R7: After reset: `ref_sel` = 0, `ext_clk` = 0, `bipolar` = 0, `cfg_q` = `CFG_DEFAULT`, `sda_oe` = 0, `hs_mode` = 0.
- R8: A repeated START, with no STOP before it, restarts address reception. The address is acknowledged again when it matches, and bytes written before the repeated START keep their effect.
- R9: A byte is committed only after all 8 bits have arrived. A STOP after fewer bits leaves both registers unchanged.
- R10: An address byte of the form 00001xxx (high-speed master code) is not acknowledged and sets `hs_mode`. A repeated START keeps `hs_mode` set, and a STOP clears it.
- R11: START and STOP are recognised as SDA falling and rising while SCL is high. `sda_oe` only asserts right after an SCL falling edge, and it is released after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull the data line low (acknowledge) |
| ref_sel | output | 3 | Reference selection field of the setup register |
| ext_clk | output | 1 | 1 = external conversion clock, 0 = internal |
| bipolar | output | 1 | 1 = bipolar input mode, 0 = unipolar |
| cfg_q | output | 7 | Configuration register contents |
| hs_mode | output | 1 | High-speed mode flag, cleared by STOP |

## Verification
The configuration load and the configuration-reset side effect both target `cfg_q`. They are reached in one transaction by writing a configuration byte followed by a setup byte with bit 1 cleared. That setup commit also loads new reference, clock and polarity fields in the same cycle. The outcome is judged at the ports after the STOP: the setup fields must show the new byte while `cfg_q` shows `CFG_DEFAULT` and not the configuration value written just before. A second run with bit 1 set, and the opposite byte order, confirms that the last configuration value survives.

// File: rtl/i2c_wr_pkg.sv
// Package: shared widths, field positions and state encoding for the
// write-only setup/configuration slave. Assumes 8-bit bus bytes.
package i2c_wr_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int CFG_W   = 7;
    localparam int REF_W   = 3;

    // Bit positions inside a setup byte (the register logic decodes these).
    localparam int SEL_BIT  = 7;
    localparam int REF_LSB  = 4;
    localparam int XCLK_BIT = 3;
    localparam int BIP_BIT  = 2;
    localparam int KEEP_BIT = 1;

    // Upper five bits of a high-speed master code.
    localparam logic [4:0] HS_CODE = 5'b00001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } bus_state_t;

    typedef struct packed {
        logic [REF_W-1:0] ref_sel;
        logic             ext_clk;
        logic             bipolar;
    } setup_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Line conditioner: synchronises SCL/SDA through SYNC_STAGES flops and
// reports SCL edges plus START/STOP conditions as one-cycle pulses.
// Assumes the system clock is at least 8x the bus clock, so that every
// bus phase spans several samples.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // Index 1 is SCL and index 0 is SDA in each stage.
    logic [1:0] stage_q [SYNC_STAGES];
    logic [1:0] prev_q;
    logic       scl_s;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        // Each stage registers the previous one; an idle bus resets high.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= 2'b11;
            end else if (g == 0) begin
                stage_q[g] <= {scl_i, sda_i};
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    // Keep the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 2'b11;
        end else begin
            prev_q <= stage_q[SYNC_STAGES-1];
        end
    end

    assign scl_s = stage_q[SYNC_STAGES-1][1];
    assign sda_s = stage_q[SYNC_STAGES-1][0];

    // Edge and bus-condition decode from the current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~prev_q[1];
        scl_fall  = ~scl_s & prev_q[1];
        start_det = scl_s & prev_q[1] & prev_q[0] & ~sda_s;
        stop_det  = scl_s & prev_q[1] & ~prev_q[0] & sda_s;
    end
endmodule

// File: rtl/i2c_wr_fsm.sv
// Byte engine: shifts in address and data bytes, matches the device
// address, drives the acknowledge and pulses wr_en once per complete data
// byte. Assumes conditioned pulses from i2c_line_sync. STOP and START take
// priority over bit handling in any state.
module i2c_wr_fsm
    import i2c_wr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              hs_mode
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    bus_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;

    assign wr_byte = shreg;

    // Bus state machine: bit capture, address decision, ACK and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            hs_mode <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                state   <= ST_IDLE;
                sda_oe  <= 1'b0;
                hs_mode <= 1'b0;
            end else if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise && bit_cnt < CNT_FULL) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CNT_FULL) begin
                            if (state == ST_ADDR) begin
                                if (shreg[BYTE_W-1:1] == DEV_ADDR && !shreg[0]) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    if (shreg[BYTE_W-1:BYTE_W-5] == HS_CODE) begin
                                        hs_mode <= 1'b1;
                                    end
                                    state <= ST_IGNORE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                wr_en  <= 1'b1;
                                state  <= ST_DATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_DATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/setup_cfg_regs.sv
// Register bank: routes each committed byte by its top bit into the setup
// or configuration register and applies the configuration-reset side
// effect. Assumes wr_en is a single-cycle pulse with wr_byte valid.
module setup_cfg_regs
    import i2c_wr_pkg::*;
#(
    parameter logic [CFG_W-1:0] CFG_DEFAULT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    output setup_t            setup_q,
    output logic [CFG_W-1:0]  cfg_q
);
    wire unused_dc = wr_byte[0];

    // Commit a byte into the register its top bit selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '0;
            cfg_q   <= CFG_DEFAULT;
        end else if (wr_en) begin
            if (wr_byte[SEL_BIT]) begin
                setup_q.ref_sel <= wr_byte[REF_LSB +: REF_W];
                setup_q.ext_clk <= wr_byte[XCLK_BIT];
                setup_q.bipolar <= wr_byte[BIP_BIT];
                if (!wr_byte[KEEP_BIT]) begin
                    cfg_q <= CFG_DEFAULT;
                end
            end else begin
                cfg_q <= wr_byte[CFG_W-1:0];
            end
        end
    end
endmodule

// File: rtl/conv_setup_i2c_slave.sv
// Top: write-only two-wire slave holding a setup and a configuration
// register for a converter. Assumes an open-drain pad outside (sda_oe
// pulls low) and a system clock at least 8x the bus clock.
module conv_setup_i2c_slave
    import i2c_wr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h36,
    parameter logic [CFG_W-1:0]  CFG_DEFAULT = '0,
    parameter int                SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [REF_W-1:0] ref_sel,
    output logic             ext_clk,
    output logic             bipolar,
    output logic [CFG_W-1:0] cfg_q,
    output logic             hs_mode
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_byte;
    setup_t            setup_q;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_wr_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .hs_mode   (hs_mode)
    );

    setup_cfg_regs #(.CFG_DEFAULT(CFG_DEFAULT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_byte (wr_byte),
        .setup_q (setup_q),
        .cfg_q   (cfg_q)
    );

    assign ref_sel = setup_q.ref_sel;
    assign ext_clk = setup_q.ext_clk;
    assign bipolar = setup_q.bipolar;
endmodule

// File: rtl/conv_setup_i2c_chk.sv
// Checker: temporal properties of the slave, bound to the top module.
// Observes the ports and the commit/condition pulses between sub-blocks.
module conv_setup_i2c_chk #(
    parameter logic [6:0] CFG_DEFAULT = '0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_fall,
    input logic       stop_det,
    input logic       wr_en,
    input logic [7:0] wr_byte,
    input logic       sda_oe,
    input logic [2:0] ref_sel,
    input logic       ext_clk,
    input logic       bipolar,
    input logic [6:0] cfg_q,
    input logic       hs_mode
);
    assert_setup_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte[7]) |=> (ref_sel == $past(wr_byte[6:4]) &&
                                   ext_clk == $past(wr_byte[3]) &&
                                   bipolar == $past(wr_byte[2])));

    assert_setup_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_byte[7]) |=> $stable({ref_sel, ext_clk, bipolar}));

    assert_cfg_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte[7]) |=> cfg_q == $past(wr_byte[6:0]));

    assert_commit_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe);

    assert_cfg_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte[7] && !wr_byte[1]) |=> cfg_q == CFG_DEFAULT);

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

    assert_hs_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hs_mode);

    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    assert_ack_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));
endmodule

bind conv_setup_i2c_slave conv_setup_i2c_chk #(.CFG_DEFAULT(CFG_DEFAULT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_fall (scl_fall),
    .stop_det (stop_det),
    .wr_en    (wr_en),
    .wr_byte  (wr_byte),
    .sda_oe   (sda_oe),
    .ref_sel  (ref_sel),
    .ext_clk  (ext_clk),
    .bipolar  (bipolar),
    .cfg_q    (cfg_q),
    .hs_mode  (hs_mode)
);

// File: tb/conv_setup_i2c_slave_tb.sv
// Scoreboard bench: bus driver tasks update a register model and push
// expected output snapshots; a monitor pops and compares them.
module conv_setup_i2c_slave_tb;
    localparam logic [6:0] DEV = 7'h36;
    localparam logic [6:0] DEF = 7'h4C;
    localparam int QTR = 10;

    typedef struct {
        logic [2:0] ref_sel;
        logic       ext_clk;
        logic       bipolar;
        logic [6:0] cfg;
        logic       hs;
        string      req;
    } snap_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_line;
    logic sda_oe, ext_clk, bipolar, hs_mode;
    logic [2:0] ref_sel;
    logic [6:0] cfg_q;

    int checks = 0;
    int failures = 0;
    snap_t sb_q[$];

    logic [2:0] e_ref = '0;
    logic       e_ext = 1'b0;
    logic       e_bip = 1'b0;
    logic [6:0] e_cfg = DEF;
    logic       e_hs  = 1'b0;

    always #2 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    conv_setup_i2c_slave #(.DEV_ADDR(DEV), .CFG_DEFAULT(DEF)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .ref_sel(ref_sel), .ext_clk(ext_clk),
        .bipolar(bipolar), .cfg_q(cfg_q), .hs_mode(hs_mode)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic q_wait();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; q_wait();
        m_scl = 1'b1; q_wait();
        m_sda = 1'b0; q_wait();
        m_scl = 1'b0; q_wait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; q_wait();
        m_scl = 1'b1; q_wait();
        m_sda = 1'b1; q_wait();
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        m_sda = b; q_wait();
        m_scl = 1'b1; q_wait();
        seen = sda_line; q_wait();
        m_scl = 1'b0; q_wait();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic dummy;
        for (int i = 7; i > 7 - n; i--) clk_bit(b[i], dummy);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        send_bits(b, 8);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    // Model of a committed data byte, taken from R3, R4 and R6.
    task automatic model_byte(input logic [7:0] b);
        if (b[7]) begin
            e_ref = b[6:4]; e_ext = b[3]; e_bip = b[2];
            if (!b[1]) e_cfg = DEF;
        end else begin
            e_cfg = b[6:0];
        end
    endtask

    // Send a data byte that must be acknowledged and committed.
    task automatic data_ok(input logic [7:0] b, input string req);
        logic a;
        send_byte(b, a);
        check(a === 1'b1, req, "data ack", a, 1);
        model_byte(b);
    endtask

    task automatic addr_ok(input string req);
        logic a;
        send_byte({DEV, 1'b0}, a);
        check(a === 1'b1, req, "address ack", a, 1);
    endtask

    // Push the expected snapshot and wait for the monitor to consume it.
    task automatic expect_now(input string req);
        snap_t s;
        s.ref_sel = e_ref; s.ext_clk = e_ext; s.bipolar = e_bip;
        s.cfg = e_cfg; s.hs = e_hs; s.req = req;
        repeat (4) @(negedge clk);
        sb_q.push_back(s);
        wait (sb_q.size() == 0);
    endtask

    // Monitor: compare each expected snapshot against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                snap_t s;
                s = sb_q.pop_front();
                check(ref_sel === s.ref_sel, s.req, "ref_sel", ref_sel, s.ref_sel);
                check(ext_clk === s.ext_clk, s.req, "ext_clk", ext_clk, s.ext_clk);
                check(bipolar === s.bipolar, s.req, "bipolar", bipolar, s.bipolar);
                check(cfg_q === s.cfg, s.req, "cfg_q", cfg_q, s.cfg);
                check(hs_mode === s.hs, s.req, "hs_mode", hs_mode, s.hs);
                check(sda_oe === 1'b0, s.req, "sda_oe idle", sda_oe, 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run time", 0, 1);
        finish_run();
    end

    initial begin
        logic a;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R7: reset state.
        expect_now("R7");

        // R1 / R3: single setup byte.
        bus_start(); addr_ok("R1");
        data_ok(8'hDE, "R5");
        bus_stop(); expect_now("R3");

        // R4: single configuration byte.
        bus_start(); addr_ok("R1");
        data_ok(8'h2B, "R5");
        bus_stop(); expect_now("R4");

        // R6: configuration then setup with reset bit 0, same transaction.
        bus_start(); addr_ok("R1");
        data_ok(8'h15, "R5");
        data_ok(8'hA1, "R6");
        bus_stop(); expect_now("R6");

        // R5 / R6: setup (reset bit 1, no action) then configuration.
        bus_start(); addr_ok("R1");
        data_ok(8'hF2, "R5");
        data_ok(8'h33, "R5");
        bus_stop(); expect_now("R6");

        // R2: foreign address, following byte ignored.
        bus_start();
        send_byte({7'h37, 1'b0}, a);
        check(a === 1'b0, "R2", "foreign address ack", a, 0);
        send_byte(8'h85, a);
        check(a === 1'b0, "R2", "ignored data ack", a, 0);
        bus_stop(); expect_now("R2");

        // R2: read direction is not acknowledged.
        bus_start();
        send_byte({DEV, 1'b1}, a);
        check(a === 1'b0, "R2", "read ack", a, 0);
        send_byte(8'h05, a);
        check(a === 1'b0, "R2", "data after read ack", a, 0);
        bus_stop(); expect_now("R2");

        // R8: repeated START between two writes.
        bus_start(); addr_ok("R1");
        data_ok(8'h9C, "R5");
        bus_start(); addr_ok("R8");
        data_ok(8'h11, "R8");
        bus_stop(); expect_now("R8");

        // R9: STOP after 4 and after 7 bits of a data byte.
        bus_start(); addr_ok("R1");
        send_bits(8'hE6, 4);
        bus_stop(); expect_now("R9");
        bus_start(); addr_ok("R1");
        send_bits(8'h05, 7);
        bus_stop(); expect_now("R9");

        // R10: master code sets the flag, repeated START keeps it, STOP clears it.
        bus_start();
        send_byte(8'h09, a);
        check(a === 1'b0, "R10", "master code ack", a, 0);
        e_hs = 1'b1;
        expect_now("R10");
        bus_start(); addr_ok("R10");
        data_ok(8'h22, "R10");
        expect_now("R10");
        bus_stop();
        e_hs = 1'b0;
        expect_now("R11");

        // R3: bit 0 of a setup byte is ignored.
        bus_start(); addr_ok("R1");
        data_ok(8'hDF, "R3");
        bus_stop(); expect_now("R3");
        bus_start(); addr_ok("R1");
        data_ok(8'hDE, "R3");
        bus_stop(); expect_now("R3");

        finish_run();
    end
endmodule